// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This block sits beside a memory arbiter and observes every access the arbiter grants. It holds a bank of watchpoint slots (four by default). Each slot compares an observed access against an inclusive address window, a mask of operation kinds and a mask of requesting clients. When all three agree, the slot records the access and sets a sticky status bit that can raise an interrupt.

Software programs the slots through a small register port. When the interrupt fires, it reads the masked status to find the slot that fired, then reads that slot's snapshot of the offending access. It clears the slot's snapshot lock with a per-slot acknowledge and clears the status bit with a separate interrupt acknowledge. The unit only observes. It never stalls or blocks the access it reports.

Top module: `watch_unit`

## Requirements
- R1: After reset the interrupt output is 0, the mask, raw status and masked status read 0, and every slot's configuration reads 0, so no access can hit.
- R2: A slot's address test passes when first ≤ address ≤ last, both bounds included, with all values compared as unsigned numbers.
- R3: The operation mask of a slot (field 0x2) enables reads with bit 0 and writes with bit 1; a kind whose bit is clear never hits.
- R4: The client mask of a slot (field 0x3) selects client id c with bit c; an access from a client whose bit is clear never hits.
- R5: A hit on slot n sets bit n of the raw status (0x01) on the next edge. The bit stays set until a write to the interrupt acknowledge (0x03) with bit n = 1. Bits written as 0 leave their status unchanged. A hit and a clear in the same cycle leave the bit set.
- R6: Bit n of the interrupt mask (0x00) gates slot n. The masked status (0x02) reads raw AND mask. The interrupt output is the OR of the masked status bits.
- R7: The first hit on an unlocked slot locks it and captures the address (field 0x6), the operation (field 0x7, 2'b01 read, 2'b10 write), the first client id (field 0x8) and the size (field 0x9). Later hits do not change these fields while the slot is locked.
- R8: The captured client set (field 0x5) is the OR of one-hot client bits of every hit since the capture, the first included.
- R9: Any write to a slot's acknowledge field (0x4) unlocks the slot (lock flag in field 0xA reads 0) and clears its client set. The raw status is unchanged. The next hit captures afresh, and a hit in the acknowledge cycle itself is captured afresh.
- R10: Slot n occupies register addresses 0x10·(n+1) + field. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is observed this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_client | input | CID_W | Requesting client id |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | SIZE_W | Access size code |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| reg_raddr | input | 8 | Register read address |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The hardest case is an access that hits in the same cycle that software clears the status or acknowledges the slot. The priority between set and clear, and between fresh capture and unlock, only shows up then. The directed tasks fire an access and a register write in one clock, then read back the status bit, the lock flag and the snapshot. Unsigned compare is tested with a window that straddles the top address bit.

// File: rtl/watch_pkg.sv
package watch_pkg;

   // Global register addresses
   localparam logic [7:0] GA_MASK   = 8'h00;
   localparam logic [7:0] GA_RAW    = 8'h01;
   localparam logic [7:0] GA_MASKED = 8'h02;
   localparam logic [7:0] GA_IACK   = 8'h03;

   // Per-slot field offsets
   typedef enum logic [3:0] {
      SF_FIRST   = 4'h0,
      SF_LAST    = 4'h1,
      SF_OPS     = 4'h2,
      SF_CLIENTS = 4'h3,
      SF_ACK     = 4'h4,
      SF_CSET    = 4'h5,
      SF_CADDR   = 4'h6,
      SF_COP     = 4'h7,
      SF_CFIRST  = 4'h8,
      SF_CSIZE   = 4'h9,
      SF_LOCK    = 4'hA
   } slot_field_e;

   localparam int OP_W = 2;   // bit 0 read, bit 1 write

endpackage

// File: rtl/watch_cmp.sv
module watch_cmp #(
   parameter int ADDR_W   = 32,
   parameter int N_CLIENT = 16,
   parameter int CID_W    = 4
) (
   input  logic [ADDR_W-1:0]   first_addr,
   input  logic [ADDR_W-1:0]   last_addr,
   input  logic [1:0]          op_mask,
   input  logic [N_CLIENT-1:0] client_mask,
   input  logic                acc_valid,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic [CID_W-1:0]    acc_client,
   input  logic                acc_write,
   output logic                hit
);
   logic in_range, op_ok, client_ok;

   always_comb begin
      in_range  = (acc_addr >= first_addr) && (acc_addr <= last_addr);
      op_ok     = acc_write ? op_mask[1] : op_mask[0];
      client_ok = 1'b0;
      for (int c = 0; c < N_CLIENT; c++)
         if (acc_client == CID_W'(c)) client_ok = client_mask[c];
      hit = acc_valid && in_range && op_ok && client_ok;
   end
endmodule

// File: rtl/watch_slot.sv
module watch_slot
   import watch_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int N_CLIENT = 16,
   parameter int CID_W    = 4,
   parameter int SIZE_W   = 4,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          wr_field,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                acc_valid,
   input  logic [ADDR_W-1:0]   acc_addr,
   input  logic [CID_W-1:0]    acc_client,
   input  logic                acc_write,
   input  logic [SIZE_W-1:0]   acc_size,
   output logic                hit,
   output logic [ADDR_W-1:0]   first_q,
   output logic [ADDR_W-1:0]   last_q,
   output logic [1:0]          ops_q,
   output logic [N_CLIENT-1:0] cmask_q,
   output logic [N_CLIENT-1:0] cset_q,
   output logic [ADDR_W-1:0]   caddr_q,
   output logic [1:0]          cop_q,
   output logic [CID_W-1:0]    cfirst_q,
   output logic [SIZE_W-1:0]   csize_q,
   output logic                locked_q
);
   logic                ack_w;
   logic [N_CLIENT-1:0] client_1h;

   watch_cmp #(.ADDR_W(ADDR_W), .N_CLIENT(N_CLIENT), .CID_W(CID_W)) i_cmp (
      .first_addr (first_q),
      .last_addr  (last_q),
      .op_mask    (ops_q),
      .client_mask(cmask_q),
      .acc_valid  (acc_valid),
      .acc_addr   (acc_addr),
      .acc_client (acc_client),
      .acc_write  (acc_write),
      .hit        (hit)
   );

   assign ack_w = wr_en && (wr_field == SF_ACK);

   always_comb begin
      client_1h = '0;
      for (int c = 0; c < N_CLIENT; c++)
         if (acc_client == CID_W'(c)) client_1h[c] = 1'b1;
   end

   // Configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
         ops_q   <= '0;
         cmask_q <= '0;
      end else if (wr_en) begin
         case (wr_field)
            SF_FIRST:   first_q <= wdata[ADDR_W-1:0];
            SF_LAST:    last_q  <= wdata[ADDR_W-1:0];
            SF_OPS:     ops_q   <= wdata[1:0];
            SF_CLIENTS: cmask_q <= wdata[N_CLIENT-1:0];
            default: ;
         endcase
      end
   end

   // Snapshot of the first hit, locked until acknowledged
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         cset_q   <= '0;
         caddr_q  <= '0;
         cop_q    <= '0;
         cfirst_q <= '0;
         csize_q  <= '0;
      end else if (hit && (!locked_q || ack_w)) begin
         locked_q <= 1'b1;
         cset_q   <= client_1h;
         caddr_q  <= acc_addr;
         cop_q    <= acc_write ? 2'b10 : 2'b01;
         cfirst_q <= acc_client;
         csize_q  <= acc_size;
      end else if (ack_w) begin
         locked_q <= 1'b0;
         cset_q   <= '0;
      end else if (hit) begin
         cset_q   <= cset_q | client_1h;
      end
   end

   p_op_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (acc_write ? ops_q[1] : ops_q[0]));

   p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && !ack_w) |=> ($stable(caddr_q) && $stable(cfirst_q) && $stable(csize_q)));

   p_cset_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && !ack_w) |=> ((cset_q & $past(cset_q)) == $past(cset_q)));

   p_ack_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_w && !hit) |=> (!locked_q && cset_q == '0));
endmodule

// File: rtl/watch_unit.sv
module watch_unit
   import watch_pkg::*;
#(
   parameter int NUM_WP   = 4,
   parameter int ADDR_W   = 32,
   parameter int N_CLIENT = 16,
   parameter int SIZE_W   = 4,
   parameter int DATA_W   = 32,
   parameter bit IRQ_REG  = 1'b0,
   localparam int CID_W   = (N_CLIENT > 1) ? $clog2(N_CLIENT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [CID_W-1:0]  acc_client,
   input  logic              acc_write,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic              reg_wr,
   input  logic [7:0]        reg_waddr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [7:0]        reg_raddr,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   initial begin
      assert (NUM_WP >= 1 && NUM_WP <= 15) else $fatal(1, "NUM_WP out of range");
      assert (DATA_W >= ADDR_W && DATA_W >= N_CLIENT && DATA_W >= NUM_WP)
         else $fatal(1, "DATA_W too narrow");
      assert (N_CLIENT >= 1) else $fatal(1, "N_CLIENT must be positive");
   end

   logic [NUM_WP-1:0]   hit, raw_q, mask_q, masked;
   logic [ADDR_W-1:0]   first_a [NUM_WP];
   logic [ADDR_W-1:0]   last_a  [NUM_WP];
   logic [1:0]          ops_a   [NUM_WP];
   logic [N_CLIENT-1:0] cmask_a [NUM_WP];
   logic [N_CLIENT-1:0] cset_a  [NUM_WP];
   logic [ADDR_W-1:0]   caddr_a [NUM_WP];
   logic [1:0]          cop_a   [NUM_WP];
   logic [CID_W-1:0]    cfirst_a[NUM_WP];
   logic [SIZE_W-1:0]   csize_a [NUM_WP];
   logic [NUM_WP-1:0]   lock_a;
   logic                iack_w;

   for (genvar n = 0; n < NUM_WP; n++) begin : g_slot
      logic slot_we;
      assign slot_we = reg_wr && (reg_waddr[7:4] == 4'(n + 1));
      watch_slot #(
         .ADDR_W(ADDR_W), .N_CLIENT(N_CLIENT), .CID_W(CID_W),
         .SIZE_W(SIZE_W), .DATA_W(DATA_W)
      ) i_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_en(slot_we), .wr_field(reg_waddr[3:0]), .wdata(reg_wdata),
         .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_client(acc_client),
         .acc_write(acc_write), .acc_size(acc_size),
         .hit(hit[n]),
         .first_q(first_a[n]), .last_q(last_a[n]), .ops_q(ops_a[n]),
         .cmask_q(cmask_a[n]), .cset_q(cset_a[n]), .caddr_q(caddr_a[n]),
         .cop_q(cop_a[n]), .cfirst_q(cfirst_a[n]), .csize_q(csize_a[n]),
         .locked_q(lock_a[n])
      );
   end

   assign iack_w = reg_wr && (reg_waddr == GA_IACK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         for (int n = 0; n < NUM_WP; n++)
            if (hit[n])                     raw_q[n] <= 1'b1;
            else if (iack_w && reg_wdata[n]) raw_q[n] <= 1'b0;
         if (reg_wr && reg_waddr == GA_MASK) mask_q <= reg_wdata[NUM_WP-1:0];
      end
   end

   assign masked = raw_q & mask_q;

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |masked;
      end
      p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q == '0) |=> !irq);
   end else begin : g_irq_comb
      assign irq = |masked;
      p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q == '0) |-> !irq);
   end

   // Combinational read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         GA_MASK:   reg_rdata = DATA_W'(mask_q);
         GA_RAW:    reg_rdata = DATA_W'(raw_q);
         GA_MASKED: reg_rdata = DATA_W'(masked);
         default: begin
            for (int n = 0; n < NUM_WP; n++) begin
               if (reg_raddr[7:4] == 4'(n + 1)) begin
                  case (reg_raddr[3:0])
                     SF_FIRST:   reg_rdata = DATA_W'(first_a[n]);
                     SF_LAST:    reg_rdata = DATA_W'(last_a[n]);
                     SF_OPS:     reg_rdata = DATA_W'(ops_a[n]);
                     SF_CLIENTS: reg_rdata = DATA_W'(cmask_a[n]);
                     SF_CSET:    reg_rdata = DATA_W'(cset_a[n]);
                     SF_CADDR:   reg_rdata = DATA_W'(caddr_a[n]);
                     SF_COP:     reg_rdata = DATA_W'(cop_a[n]);
                     SF_CFIRST:  reg_rdata = DATA_W'(cfirst_a[n]);
                     SF_CSIZE:   reg_rdata = DATA_W'(csize_a[n]);
                     SF_LOCK:    reg_rdata = DATA_W'(lock_a[n]);
                     default:    reg_rdata = '0;
                  endcase
               end
            end
         end
      endcase
   end

   p_raw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((raw_q & $past(hit)) == $past(hit)));

   p_masked_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_raddr == GA_MASKED) && !(reg_rdata[NUM_WP-1:0] == (raw_q & mask_q))) |-> 1'b0);
endmodule

// File: tb/test_watch_unit.sv
module test_watch_unit;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [3:0]        acc_client = '0;
   logic              acc_write = 1'b0;
   logic [3:0]        acc_size = '0;
   logic              reg_wr = 1'b0;
   logic [7:0]        reg_waddr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [7:0]        reg_raddr = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irq;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #2 clk = ~clk;

   watch_unit i_watch_unit (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_client(acc_client),
      .acc_write(acc_write), .acc_size(acc_size),
      .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq)
   );

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   // One clock: optional access and optional register write in the same cycle
   task automatic cyc(input bit av, input logic [31:0] a, input logic [3:0] c,
                      input bit w, input logic [3:0] sz,
                      input bit rw, input logic [7:0] ra, input logic [31:0] rd);
      @(negedge clk);
      acc_valid = av; acc_addr = a; acc_client = c; acc_write = w; acc_size = sz;
      reg_wr = rw; reg_waddr = ra; reg_wdata = rd;
      @(negedge clk);
      acc_valid = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(0, 0, 0, 0, 0, 1, a, d);
   endtask

   task automatic acc(input logic [31:0] a, input logic [3:0] c, input bit w, input logic [3:0] sz);
      cyc(1, a, c, w, sz, 0, 0, 0);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_raddr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic setup0(input logic [31:0] f, input logic [31:0] l, input logic [1:0] ops, input logic [15:0] cm);
      wr(8'h10, f); wr(8'h11, l); wr(8'h12, 32'(ops)); wr(8'h13, 32'(cm));
      wr(8'h14, 0); wr(8'h03, 32'hF);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R1 irq", 32'(irq), 0);
      rd(8'h00, d); check("R1 mask", d, 0);
      rd(8'h01, d); check("R1 raw", d, 0);
      rd(8'h02, d); check("R1 masked", d, 0);
      rd(8'h12, d); check("R1 ops", d, 0);
      rd(8'h21, d); check("R1 last slot1", d, 0);
      acc(32'h0, 0, 1, 0);
      rd(8'h01, d); check("R1 no hit after reset", d, 0);
   endtask

   task automatic t_range;
      logic [31:0] d;
      setup0(32'h100, 32'h1FF, 2'b11, 16'hFFFF);
      acc(32'hFF, 0, 0, 0);  rd(8'h01, d); check("R2 below first", d, 0);
      acc(32'h100, 0, 0, 0); rd(8'h01, d); check("R2 at first", d, 1);
      wr(8'h03, 1);
      acc(32'h1FF, 0, 0, 0); rd(8'h01, d); check("R2 at last", d, 1);
      wr(8'h03, 1);
      acc(32'h200, 0, 0, 0); rd(8'h01, d); check("R2 above last", d, 0);
      setup0(32'h100, 32'hFFFF_FFFF, 2'b11, 16'hFFFF);
      acc(32'h8000_0000, 0, 0, 0); rd(8'h01, d); check("R2 unsigned high", d, 1);
   endtask

   task automatic t_ops;
      logic [31:0] d;
      setup0(32'h0, 32'hFFFF, 2'b10, 16'hFFFF);
      acc(32'h10, 0, 0, 0); rd(8'h01, d); check("R3 read blocked", d, 0);
      acc(32'h10, 0, 1, 0); rd(8'h01, d); check("R3 write hits", d, 1);
      setup0(32'h0, 32'hFFFF, 2'b01, 16'hFFFF);
      acc(32'h10, 0, 1, 0); rd(8'h01, d); check("R3 write blocked", d, 0);
      acc(32'h10, 0, 0, 0); rd(8'h01, d); check("R3 read hits", d, 1);
   endtask

   task automatic t_clients;
      logic [31:0] d;
      setup0(32'h0, 32'hFFFF, 2'b11, 16'h0020);
      acc(32'h10, 4, 0, 0); rd(8'h01, d); check("R4 client4 blocked", d, 0);
      acc(32'h10, 5, 0, 0); rd(8'h01, d); check("R4 client5 hits", d, 1);
   endtask

   task automatic t_status;
      logic [31:0] d;
      setup0(32'h0, 32'hFFFF, 2'b11, 16'hFFFF);
      acc(32'h10, 0, 0, 0);
      wr(8'h03, 32'h0); rd(8'h01, d); check("R5 zero ack keeps", d, 1);
      wr(8'h03, 32'h1); rd(8'h01, d); check("R5 ack clears", d, 0);
      cyc(1, 32'h10, 0, 0, 0, 1, 8'h03, 32'h1);
      rd(8'h01, d); check("R5 set beats clear", d, 1);
      wr(8'h03, 32'hF);
   endtask

   task automatic t_mask;
      logic [31:0] d;
      wr(8'h30, 32'h0); wr(8'h31, 32'hFFFF); wr(8'h32, 3); wr(8'h33, 32'hFFFF);
      wr(8'h12, 0);
      wr(8'h00, 32'h0);
      acc(32'h40, 1, 0, 0);
      rd(8'h01, d); check("R6 raw slot2", d, 32'h4);
      rd(8'h02, d); check("R6 masked off", d, 0);
      check("R6 irq off", 32'(irq), 0);
      wr(8'h00, 32'h4);
      rd(8'h02, d); check("R6 masked on", d, 32'h4);
      check("R6 irq on", 32'(irq), 1);
      wr(8'h03, 32'h4);
      check("R6 irq after clear", 32'(irq), 0);
      wr(8'h00, 0); wr(8'h32, 0);
   endtask

   task automatic t_capture;
      logic [31:0] d;
      setup0(32'h100, 32'h1FF, 2'b11, 16'hFFFF);
      acc(32'h120, 3, 1, 2);
      acc(32'h130, 7, 0, 1);
      rd(8'h16, d); check("R7 cap addr", d, 32'h120);
      rd(8'h17, d); check("R7 cap op", d, 32'h2);
      rd(8'h18, d); check("R7 cap first client", d, 3);
      rd(8'h19, d); check("R7 cap size", d, 2);
      rd(8'h15, d); check("R8 client set", d, 32'h88);
      rd(8'h1A, d); check("R9 locked", d, 1);
      wr(8'h14, 0);
      rd(8'h1A, d); check("R9 unlocked", d, 0);
      rd(8'h15, d); check("R9 set cleared", d, 0);
      rd(8'h01, d); check("R9 raw kept", d, 1);
      acc(32'h140, 1, 0, 3);
      rd(8'h16, d); check("R9 fresh addr", d, 32'h140);
      rd(8'h15, d); check("R9 fresh set", d, 32'h2);
      cyc(1, 32'h150, 9, 1, 1, 1, 8'h14, 0);
      rd(8'h16, d); check("R9 ack+hit addr", d, 32'h150);
      rd(8'h15, d); check("R9 ack+hit set", d, 32'h200);
      rd(8'h1A, d); check("R9 ack+hit locked", d, 1);
   endtask

   task automatic t_map;
      logic [31:0] d;
      wr(8'h20, 32'hABC);
      rd(8'h20, d); check("R10 slot1 first", d, 32'hABC);
      rd(8'h10, d); check("R10 slot0 untouched", d, 32'h100);
      rd(8'h0F, d); check("R10 unmapped", d, 0);
      rd(8'h60, d); check("R10 beyond slots", d, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset;
      t_range;
      t_ops;
      t_clients;
      t_status;
      t_mask;
      t_capture;
      t_map;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule